// File: doc/BRIEF.md
# RTC Register Block with Maskable Interrupts

This block is the register front end of a real-time clock. It keeps a seconds count, a compare value for an alarm, a control word, a scratch word and two interrupt groups. The group for time events has two status bits: one for the seconds strobe and one for the alarm match. The group for bus faults has one status bit. Each group has its own level interrupt output.

A separate divider supplies the one-second strobe `tick_sec`. Software uses a simple single-cycle request bus. A request is one cycle long. Read data and a valid flag come back on the next cycle. Writes take effect at the clock edge that accepts the request.

Software cannot write the interrupt masks directly. It unmasks bits by writing ones to an enable register, and masks them by writing ones to a disable register. Both masks start fully masked.

Top module: `rtc_regblock`

Register map (byte offsets; word index is `bus_addr[5:2]`):

| Offset | Name | Access |
|---|---|---|
| 0x00 | NOW | RO, live count |
| 0x04 | LOAD | write loads count, read returns live count |
| 0x08 | ALARM | RW |
| 0x0C | CTRL | RW under mask 0x8F000001 |
| 0x10 | SUBSEC | RO, reads 0 |
| 0x14 | TRIM | RO, reads TRIM_INIT[20:0] |
| 0x18 | SCRATCH | RW |
| 0x1C | hole | unmapped |
| 0x20 | EV_STAT | write-1-to-clear |
| 0x24 | EV_MASK | RO |
| 0x28 | EV_EN | write-only, reads 0 |
| 0x2C | EV_DIS | write-only, reads 0 |
| 0x30 | AE_STAT | write-1-to-clear |
| 0x34 | AE_MASK | RO |
| 0x38 | AE_EN | write-only, reads 0 |
| 0x3C | AE_DIS | write-only, reads 0 |

## Requirements
- R1: After reset, EV_MASK (0x24) reads 0x3, AE_MASK (0x34) reads 0x1, CTRL (0x0C) reads 0x01000000, and both irq outputs are low.
- R2: A valid write to LOAD (0x04) sets the seconds count to the write data at that clock edge. Reads of NOW (0x00) and LOAD (0x04) return the live count. A load in the same cycle as `tick_sec` wins over the increment.
- R3: Each cycle with `tick_sec` high adds one to the count and sets EV_STAT bit 0.
- R4: ALARM (0x08) is read/write. EV_STAT bit 1 is set in every cycle where the count equals ALARM.
- R5: Writing 1 to a bit of EV_STAT (0x20) or AE_STAT (0x30) clears that bit. A hardware set in the same cycle takes priority over the clear.
- R6: Direct writes to EV_MASK and AE_MASK are ignored. A 1 written to EV_EN (0x28) or AE_EN (0x38) clears that mask bit. A 1 written to EV_DIS (0x2C) or AE_DIS (0x3C) sets it. The enable and disable offsets read 0.
- R7: `irq_event` is high exactly when a bit is set in EV_STAT and clear in EV_MASK. `irq_addr_err` follows the same rule for the address-error group. Both are registered and reflect a status, enable or disable write from the edge that accepts it.
- R8: In CTRL, only the bits in 0x8F000001 can be written. All other bits keep their value.
- R9: TRIM (0x14) reads TRIM_INIT[20:0] and ignores writes. SUBSEC (0x10) reads 0. SCRATCH (0x18) is read/write.
- R10: An access is bad if any byte enable is low, if `bus_addr[1:0]` is nonzero, if the offset is 0x1C, or if the offset is 0x40 or above. A bad access sets AE_STAT bit 0, returns 0 when it is a read, and changes no register when it is a write.
- R11: Read data and `bus_rvalid` appear one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_sec | input | 1 | One-second strobe, one cycle wide |
| bus_req | input | 1 | Access request, one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables; all four must be set |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after request |
| irq_event | output | 1 | Time-event interrupt level |
| irq_addr_err | output | 1 | Address-error interrupt level |

## Verification
The bench uses the default parameters: ADDR_W = 8, CNT_W = 32 and TRIM_INIT = 0xFFF23456. The 8-bit address reaches both the unmapped space above 0x3F and the hole at 0x1C. The full-width count reaches the alarm compare at arbitrary values. The TRIM_INIT default has bits set above bit 20, so the bench checks that the trim register drops them.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int unsigned DATA_W    = 32;
  localparam int unsigned BE_W      = DATA_W / 8;
  localparam int unsigned IDX_W     = 4;
  localparam int unsigned EV_W      = 2;
  localparam int unsigned AE_W      = 1;
  localparam logic [31:0] CTRL_RST  = 32'h0100_0000;
  localparam logic [31:0] CTRL_WMSK = 32'h8F00_0001;
  localparam logic [31:0] TRIM_MSK  = 32'h001F_FFFF;

  typedef enum logic [IDX_W-1:0] {
    W_NOW     = 4'd0,
    W_LOAD    = 4'd1,
    W_ALARM   = 4'd2,
    W_CTRL    = 4'd3,
    W_SUBSEC  = 4'd4,
    W_TRIM    = 4'd5,
    W_SCRATCH = 4'd6,
    W_HOLE    = 4'd7,
    W_EVST    = 4'd8,
    W_EVMSK   = 4'd9,
    W_EVEN    = 4'd10,
    W_EVDIS   = 4'd11,
    W_AEST    = 4'd12,
    W_AEMSK   = 4'd13,
    W_AEEN    = 4'd14,
    W_AEDIS   = 4'd15
  } reg_idx_e;

endpackage

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_val,
  input  logic             alarm_we,
  input  logic [CNT_W-1:0] alarm_val,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] alarm,
  output logic             alarm_hit
);

  // load has priority over the strobe increment
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load_we) begin
      count <= load_val;
    end else if (tick) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm <= '0;
    end else if (alarm_we) begin
      alarm <= alarm_val;
    end
  end

  assign alarm_hit = (count == alarm);

endmodule

// File: rtl/rtc_irq_bank.sv
module rtc_irq_bank #(
  parameter int unsigned   W        = 2,
  parameter logic [W-1:0]  MASK_RST = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] hw_set,
  input  logic         clr_we,
  input  logic         en_we,
  input  logic         dis_we,
  input  logic [W-1:0] wval,
  output logic [W-1:0] stat,
  output logic [W-1:0] mask,
  output logic         irq
);

  logic [W-1:0] stat_d;
  logic [W-1:0] mask_d;

  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    // a hardware set beats a write-1-clear in the same cycle
    assign stat_d[gi] = hw_set[gi] | (stat[gi] & ~(clr_we & wval[gi]));
    assign mask_d[gi] = (dis_we & wval[gi]) | (mask[gi] & ~(en_we & wval[gi]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      mask <= MASK_RST;
      irq  <= 1'b0;
    end else begin
      stat <= stat_d;
      mask <= mask_d;
      irq  <= |(stat_d & ~mask_d);
    end
  end

endmodule

// File: rtl/rtc_regblock.sv
module rtc_regblock #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CNT_W     = 32,
  parameter logic [31:0] TRIM_INIT = 32'hFFF2_3456
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_sec,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              irq_event,
  output logic              irq_addr_err
);
  import rtc_pkg::*;

  localparam int unsigned MAP_BITS = IDX_W + 2;

  reg_idx_e               idx;
  logic                   in_map;
  logic                   acc_ok;
  logic                   bad_acc;
  logic                   wr_ok;
  logic [CNT_W-1:0]       sec_count;
  logic [CNT_W-1:0]       alarm_q;
  logic                   alarm_hit;
  logic [EV_W-1:0]        ev_stat, ev_mask;
  logic [AE_W-1:0]        ae_stat, ae_mask;
  logic [31:0]            ctrl_q;
  logic [31:0]            scratch_q;
  logic [31:0]            rd_mux;

  assign idx     = reg_idx_e'(bus_addr[MAP_BITS-1:2]);
  assign in_map  = (bus_addr[ADDR_W-1:MAP_BITS] == '0);
  assign acc_ok  = in_map && (bus_addr[1:0] == 2'b00) && (&bus_be) && (idx != W_HOLE);
  assign bad_acc = bus_req && !acc_ok;
  assign wr_ok   = bus_req && bus_we && acc_ok;

  rtc_seconds #(.CNT_W(CNT_W)) u_sec (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_sec),
    .load_we   (wr_ok && idx == W_LOAD),
    .load_val  (bus_wdata[CNT_W-1:0]),
    .alarm_we  (wr_ok && idx == W_ALARM),
    .alarm_val (bus_wdata[CNT_W-1:0]),
    .count     (sec_count),
    .alarm     (alarm_q),
    .alarm_hit (alarm_hit)
  );

  rtc_irq_bank #(.W(EV_W), .MASK_RST({EV_W{1'b1}})) u_ev (
    .clk    (clk),
    .rst    (rst),
    .hw_set ({alarm_hit, tick_sec}),
    .clr_we (wr_ok && idx == W_EVST),
    .en_we  (wr_ok && idx == W_EVEN),
    .dis_we (wr_ok && idx == W_EVDIS),
    .wval   (bus_wdata[EV_W-1:0]),
    .stat   (ev_stat),
    .mask   (ev_mask),
    .irq    (irq_event)
  );

  rtc_irq_bank #(.W(AE_W), .MASK_RST({AE_W{1'b1}})) u_ae (
    .clk    (clk),
    .rst    (rst),
    .hw_set (bad_acc),
    .clr_we (wr_ok && idx == W_AEST),
    .en_we  (wr_ok && idx == W_AEEN),
    .dis_we (wr_ok && idx == W_AEDIS),
    .wval   (bus_wdata[AE_W-1:0]),
    .stat   (ae_stat),
    .mask   (ae_mask),
    .irq    (irq_addr_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= CTRL_RST;
      scratch_q <= '0;
    end else begin
      if (wr_ok && idx == W_CTRL) begin
        ctrl_q <= (ctrl_q & ~CTRL_WMSK) | (bus_wdata & CTRL_WMSK);
      end
      if (wr_ok && idx == W_SCRATCH) begin
        scratch_q <= bus_wdata;
      end
    end
  end

  always_comb begin
    case (idx)
      W_NOW, W_LOAD: rd_mux = 32'(sec_count);
      W_ALARM:       rd_mux = 32'(alarm_q);
      W_CTRL:        rd_mux = ctrl_q;
      W_TRIM:        rd_mux = TRIM_INIT & TRIM_MSK;
      W_SCRATCH:     rd_mux = scratch_q;
      W_EVST:        rd_mux = 32'(ev_stat);
      W_EVMSK:       rd_mux = 32'(ev_mask);
      W_AEST:        rd_mux = 32'(ae_stat);
      W_AEMSK:       rd_mux = 32'(ae_mask);
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_req && !bus_we;
      if (bus_req && !bus_we) begin
        bus_rdata <= acc_ok ? rd_mux : '0;
      end
    end
  end

endmodule

// File: rtl/rtc_regblock_chk.sv
module rtc_regblock_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_sec,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_be,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              irq_event,
  input logic              irq_addr_err,
  input logic [CNT_W-1:0]  sec_count,
  input logic [1:0]        ev_stat,
  input logic [1:0]        ev_mask,
  input logic              ae_stat,
  input logic              ae_mask
);

  logic good_wr;
  assign good_wr = bus_req && bus_we && (bus_be == 4'hF);

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    (good_wr && bus_addr == ADDR_W'(8'h04)) |=> sec_count == $past(bus_wdata[CNT_W-1:0]));

  // R3
  tick_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_sec && !(good_wr && bus_addr == ADDR_W'(8'h04)))
      |=> sec_count == CNT_W'($past(sec_count) + 1'b1));

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    tick_sec |=> ev_stat[0]);

  // R6
  en_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (good_wr && bus_addr == ADDR_W'(8'h28)) |=> (ev_mask & $past(bus_wdata[1:0])) == 2'b00);

  // R7
  ev_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_mask == 2'b11) |-> !irq_event);

  // R7
  ae_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ae_mask |-> !irq_addr_err);

  // R10
  bad_be_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_be != 4'hF) |=> ae_stat);

  // R10
  bad_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we && bus_be != 4'hF) |=> (bus_rdata == 32'h0 && bus_rvalid));

endmodule

bind rtc_regblock rtc_regblock_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .tick_sec     (tick_sec),
  .bus_req      (bus_req),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .bus_be       (bus_be),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .bus_rvalid   (bus_rvalid),
  .irq_event    (irq_event),
  .irq_addr_err (irq_addr_err),
  .sec_count    (sec_count),
  .ev_stat      (ev_stat),
  .ev_mask      (ev_mask),
  .ae_stat      (ae_stat),
  .ae_mask      (ae_mask)
);

// File: tb/test_rtc_regblock.sv
`timescale 1ns/1ps
module test_rtc_regblock;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_sec = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq_event;
  logic        irq_addr_err;

  int n_chk = 0;
  int n_bad = 0;
  logic last_rvalid;

  localparam logic [7:0] A_NOW = 8'h00, A_LOAD = 8'h04, A_ALARM = 8'h08, A_CTRL = 8'h0C,
                         A_SUBSEC = 8'h10, A_TRIM = 8'h14, A_SCR = 8'h18, A_HOLE = 8'h1C,
                         A_EVST = 8'h20, A_EVMSK = 8'h24, A_EVEN = 8'h28, A_EVDIS = 8'h2C,
                         A_AEST = 8'h30, A_AEMSK = 8'h34, A_AEEN = 8'h38, A_AEDIS = 8'h3C;

  always #2.5 clk = ~clk;

  rtc_regblock i_rtc_regblock (
    .clk (clk), .rst (rst), .tick_sec (tick_sec),
    .bus_req (bus_req), .bus_we (bus_we), .bus_addr (bus_addr), .bus_be (bus_be),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .bus_rvalid (bus_rvalid),
    .irq_event (irq_event), .irq_addr_err (irq_addr_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; bus_be = 4'h0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = be;
    @(negedge clk);
    bus_req = 1'b0; bus_be = 4'h0;
    d = bus_rdata;
    last_rvalid = bus_rvalid;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick_sec = 1'b1;
    @(negedge clk); tick_sec = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq_event after reset", 32'(irq_event), 32'h0);
    check("R1 irq_addr_err after reset", 32'(irq_addr_err), 32'h0);
    rd(A_EVMSK, v); check("R1 event mask reset", v, 32'h3);
    check("R11 rvalid one cycle after read", 32'(last_rvalid), 32'h1);
    rd(A_AEMSK, v); check("R1 addr-err mask reset", v, 32'h1);
    rd(A_CTRL, v);  check("R1 ctrl reset", v, 32'h0100_0000);
  endtask

  task automatic t_load();
    logic [31:0] v;
    wr(A_LOAD, 32'h100);
    rd(A_NOW, v);  check("R2 NOW after load", v, 32'h100);
    rd(A_LOAD, v); check("R2 LOAD reads live count", v, 32'h100);
    pulse_tick();
    rd(A_NOW, v);  check("R3 count after tick", v, 32'h101);
  endtask

  task automatic t_events();
    logic [31:0] v;
    wr(A_EVST, 32'h3);
    rd(A_EVST, v); check("R5 status cleared", v, 32'h0);
    pulse_tick();
    rd(A_EVST, v); check("R3 tick sets bit0", v, 32'h1);
    check("R7 masked irq low", 32'(irq_event), 32'h0);
    wr(A_EVMSK, 32'h0);
    rd(A_EVMSK, v); check("R6 direct mask write ignored", v, 32'h3);
    wr(A_EVEN, 32'h1);
    check("R7 irq after enable", 32'(irq_event), 32'h1);
    rd(A_EVMSK, v); check("R6 enable clears mask bit", v, 32'h2);
    rd(A_EVEN, v);  check("R6 enable reads zero", v, 32'h0);
    wr(A_EVST, 32'h1);
    check("R7 irq after clear", 32'(irq_event), 32'h0);
    wr(A_EVDIS, 32'h1);
    rd(A_EVMSK, v); check("R6 disable sets mask bit", v, 32'h3);
    rd(A_EVDIS, v); check("R6 disable reads zero", v, 32'h0);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    @(negedge clk);
    tick_sec = 1'b1; bus_req = 1'b1; bus_we = 1'b1; bus_addr = A_EVST; bus_wdata = 32'h1; bus_be = 4'hF;
    @(negedge clk);
    tick_sec = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_be = 4'h0;
    rd(A_EVST, v); check("R5 set beats clear", v, 32'h1);
    wr(A_EVST, 32'h1);
    @(negedge clk);
    tick_sec = 1'b1; bus_req = 1'b1; bus_we = 1'b1; bus_addr = A_LOAD; bus_wdata = 32'h50; bus_be = 4'hF;
    @(negedge clk);
    tick_sec = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_be = 4'h0;
    rd(A_NOW, v); check("R2 load beats tick", v, 32'h50);
  endtask

  task automatic t_alarm();
    logic [31:0] v;
    wr(A_ALARM, 32'h200);
    rd(A_ALARM, v); check("R4 alarm readback", v, 32'h200);
    wr(A_LOAD, 32'h1FF);
    wr(A_EVST, 32'h3);
    rd(A_EVST, v); check("R4 no match before tick", v, 32'h0);
    pulse_tick();
    rd(A_EVST, v); check("R4 alarm match sets bit1", v, 32'h3);
    wr(A_EVEN, 32'h2);
    check("R7 irq from alarm bit", 32'(irq_event), 32'h1);
    wr(A_EVDIS, 32'h2);
    check("R7 irq masked again", 32'(irq_event), 32'h0);
    wr(A_LOAD, 32'h10);
    wr(A_EVST, 32'h3);
  endtask

  task automatic t_ctrl_misc();
    logic [31:0] v;
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); check("R8 ctrl write mask", v, 32'h8F00_0001);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); check("R8 ctrl cleared", v, 32'h0);
    rd(A_TRIM, v); check("R9 trim value", v, 32'h0012_3456);
    wr(A_TRIM, 32'h0);
    rd(A_TRIM, v); check("R9 trim write ignored", v, 32'h0012_3456);
    rd(A_SUBSEC, v); check("R9 subsec zero", v, 32'h0);
    wr(A_SCR, 32'hA5A5_5A5A);
    rd(A_SCR, v); check("R9 scratch", v, 32'hA5A5_5A5A);
  endtask

  task automatic t_addr_err();
    logic [31:0] v;
    rd(A_AEST, v); check("R10 no error yet", v, 32'h0);
    rd(A_HOLE, v); check("R10 hole reads zero", v, 32'h0);
    check("R7 ae irq masked", 32'(irq_addr_err), 32'h0);
    rd(A_AEST, v); check("R10 hole sets error", v, 32'h1);
    wr(A_AEMSK, 32'h0);
    rd(A_AEMSK, v); check("R6 ae mask write ignored", v, 32'h1);
    wr(A_AEEN, 32'h1);
    check("R7 ae irq after enable", 32'(irq_addr_err), 32'h1);
    wr(A_AEST, 32'h1);
    check("R5 ae clear drops irq", 32'(irq_addr_err), 32'h0);
    wr(A_ALARM, 32'h77, 4'h3);
    rd(A_ALARM, v); check("R10 partial write no effect", v, 32'h200);
    rd(A_AEST, v); check("R10 partial write sets error", v, 32'h1);
    wr(A_AEST, 32'h1);
    rd(A_SCR, v, 4'h7); check("R10 partial read zero", v, 32'h0);
    wr(A_AEST, 32'h1);
    rd(8'h80, v); check("R10 out of range reads zero", v, 32'h0);
    wr(A_AEST, 32'h1);
    rd(8'h19, v); check("R10 misaligned reads zero", v, 32'h0);
    check("R7 ae irq on misaligned", 32'(irq_addr_err), 32'h1);
    wr(A_AEDIS, 32'h1);
    rd(A_AEMSK, v); check("R6 ae disable", v, 32'h1);
    check("R7 ae irq masked by disable", 32'(irq_addr_err), 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load();
    t_events();
    t_priority();
    t_alarm();
    t_ctrl_misc();
    t_addr_err();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule